// File: doc/BRIEF.md
# DMA Descriptor Condition Evaluator

This block makes the three conditional decisions a descriptor-driven DMA channel needs when a command finishes: raise an interrupt, hold the channel waiting, and take the branch to the alternate command address. Each decision has a two-bit policy in the command word and a select register of its own, written by software. The select register carries a compare value in its low bits and a mask higher up. The evaluator masks the channel's device-status bits and the compare value with the same mask and compares them. The policy then decides whether the decision fires never, always, only when the comparison matches or only when it does not.

The sequencer that walks the descriptor list asserts `eval_strobe` for one cycle per completed command, with the command word, the device status and the three select registers valid in that cycle. On the next clock the evaluator reports the result. The interrupt request is a single-cycle pulse. The wait and branch-taken flags are levels that hold until the next evaluation. A wait decision has priority. While the channel is held, no interrupt is raised and the branch-taken flag keeps its previous value, because the command has not yet completed.

Top module: `dma_cond_eval`

## Requirements
- R1: Synchronous reset clears `result_valid`, `irq_raise`, `wait_hold` and `branch_taken` to 0.
- R2: For a given select register, the condition is true when, for every bit where the mask in bits 19:16 is 1, the device-status bit equals the compare bit in bits 3:0. Select bits outside these two fields have no effect. A zero mask makes the condition true.
- R3: Each policy field is decoded as 00 = never, 01 = fire when the condition is true, 10 = fire when it is false, 11 = always.
- R4: The interrupt policy is command bits 5:4, the branch policy is bits 3:2 and the wait policy is bits 1:0. All other command bits have no effect.
- R5: The interrupt, branch and wait decisions are each tested against their own select register (`intr_select`, `branch_select`, `wait_select`).
- R6: `result_valid` is high in exactly the cycles that follow a cycle with `eval_strobe` high. This holds for back-to-back strobes too, with one result per strobe.
- R7: `irq_raise` is high only together with `result_valid`, as a one-cycle pulse per firing evaluation.
- R8: When the wait decision does not fire, `branch_taken` becomes 1 if the branch decision fires and 0 otherwise.
- R9: When the wait decision fires, `wait_hold` becomes 1, `irq_raise` stays 0 and `branch_taken` keeps its previous value.
- R10: In cycles that follow no strobe, `wait_hold` and `branch_taken` keep their values and `irq_raise` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_strobe | input | 1 | Evaluate the current command in this cycle |
| cmd_word | input | CMD_W (16) | Descriptor command word holding the three policy fields |
| dev_status | input | STATUS_W (4) | Device-status bits of the channel |
| intr_select | input | SEL_W (32) | Mask and compare value for the interrupt decision |
| branch_select | input | SEL_W (32) | Mask and compare value for the branch decision |
| wait_select | input | SEL_W (32) | Mask and compare value for the wait decision |
| result_valid | output | 1 | Result of the previous cycle's strobe is present |
| irq_raise | output | 1 | Interrupt request pulse |
| wait_hold | output | 1 | Channel must wait before completing the command |
| branch_taken | output | 1 | Last completed command took its branch |

## Verification
The bench builds the block with its default parameters: four status bits, the mask at bit 16, the compare value at bit 0 and a 16-bit command word. With these values every policy code can be swept on each of the three fields, with the condition both matching and failing. Partial and empty masks can be combined with noise in the unused select and command bits. Back-to-back strobes, the wait priority over a branch already taken and idle stretches are all reachable in a few hundred cycles.

// File: rtl/dma_cond_pkg.sv
package dma_cond_pkg;

    // Policy codes carried in each two-bit command field
    typedef enum logic [1:0] {
        POL_NEVER    = 2'b00,
        POL_IF_TRUE  = 2'b01,
        POL_IF_FALSE = 2'b10,
        POL_ALWAYS   = 2'b11
    } policy_e;

    localparam int POLICY_W    = 2;
    localparam int NUM_LANES   = 3;
    localparam int LANE_WAIT   = 0;
    localparam int LANE_BRANCH = 1;
    localparam int LANE_INTR   = 2;

    // Decision bundle carried from the lanes into the register stage
    typedef struct packed {
        logic intr;
        logic hold;
        logic branch;
    } decision_t;

    // Command-word position of a lane's policy field
    function automatic int lane_field_lsb(input int lane);
        return lane * POLICY_W;
    endfunction

    // Policy resolution against a condition outcome
    function automatic logic policy_fires(input policy_e pol, input logic cond);
        logic f;
        unique case (pol)
            POL_NEVER:    f = 1'b0;
            POL_IF_TRUE:  f = cond;
            POL_IF_FALSE: f = ~cond;
            POL_ALWAYS:   f = 1'b1;
            default:      f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/cond_match.sv
module cond_match #(
    parameter int STATUS_W  = 4,
    parameter int SEL_W     = 32,
    parameter int MASK_LSB  = 16,
    parameter int VALUE_LSB = 0
) (
    input  logic [STATUS_W-1:0] status,
    input  logic [SEL_W-1:0]    sel,
    output logic                hit
);
    logic [STATUS_W-1:0] mask;
    logic [STATUS_W-1:0] value;
    logic [STATUS_W-1:0] diff;
    logic                sel_unused;

    assign mask       = sel[MASK_LSB +: STATUS_W];
    assign value      = sel[VALUE_LSB +: STATUS_W];
    assign sel_unused = ^sel;

    // A bit disagrees only where the mask selects it
    for (genvar b = 0; b < STATUS_W; b++) begin : g_bit
        assign diff[b] = mask[b] & (status[b] ^ value[b]);
    end

    assign hit = ~|diff;
endmodule

// File: rtl/policy_decode.sv
module policy_decode
    import dma_cond_pkg::*;
#(
    parameter int CMD_W     = 16,
    parameter int FIELD_LSB = 0
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic             hit,
    output logic             fire
);
    policy_e pol;
    logic    cmd_unused;

    assign pol        = policy_e'(cmd[FIELD_LSB +: POLICY_W]);
    assign cmd_unused = ^cmd;
    assign fire       = policy_fires(pol, hit);
endmodule

// File: rtl/decision_reg.sv
module decision_reg
    import dma_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  decision_t fire,
    output logic      valid,
    output decision_t state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            state <= '0;
        end else begin
            valid      <= strobe;
            // Interrupt pulses only when the command completes
            state.intr <= strobe & fire.intr & ~fire.hold;
            if (strobe) begin
                state.hold <= fire.hold;
                if (!fire.hold) begin
                    state.branch <= fire.branch;
                end
            end
        end
    end
endmodule

// File: rtl/dma_cond_eval.sv
module dma_cond_eval
    import dma_cond_pkg::*;
#(
    parameter int CMD_W     = 16,
    parameter int STATUS_W  = 4,
    parameter int SEL_W     = 32,
    parameter int MASK_LSB  = 16,
    parameter int VALUE_LSB = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                eval_strobe,
    input  logic [CMD_W-1:0]    cmd_word,
    input  logic [STATUS_W-1:0] dev_status,
    input  logic [SEL_W-1:0]    intr_select,
    input  logic [SEL_W-1:0]    branch_select,
    input  logic [SEL_W-1:0]    wait_select,
    output logic                result_valid,
    output logic                irq_raise,
    output logic                wait_hold,
    output logic                branch_taken
);
    logic [NUM_LANES-1:0][SEL_W-1:0] sel_bus;
    logic [NUM_LANES-1:0]            lane_hit;
    logic [NUM_LANES-1:0]            lane_fire;
    decision_t                       fire_d;
    decision_t                       state_q;

    assign sel_bus[LANE_WAIT]   = wait_select;
    assign sel_bus[LANE_BRANCH] = branch_select;
    assign sel_bus[LANE_INTR]   = intr_select;

    // One masked comparator and one policy decoder per decision
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        cond_match #(
            .STATUS_W (STATUS_W),
            .SEL_W    (SEL_W),
            .MASK_LSB (MASK_LSB),
            .VALUE_LSB(VALUE_LSB)
        ) u_match (
            .status(dev_status),
            .sel   (sel_bus[g]),
            .hit   (lane_hit[g])
        );

        policy_decode #(
            .CMD_W    (CMD_W),
            .FIELD_LSB(lane_field_lsb(g))
        ) u_policy (
            .cmd (cmd_word),
            .hit (lane_hit[g]),
            .fire(lane_fire[g])
        );
    end

    assign fire_d.intr   = lane_fire[LANE_INTR];
    assign fire_d.hold   = lane_fire[LANE_WAIT];
    assign fire_d.branch = lane_fire[LANE_BRANCH];

    decision_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .strobe(eval_strobe),
        .fire  (fire_d),
        .valid (result_valid),
        .state (state_q)
    );

    assign irq_raise    = state_q.intr;
    assign wait_hold    = state_q.hold;
    assign branch_taken = state_q.branch;
endmodule

// File: rtl/dma_cond_eval_chk.sv
module dma_cond_eval_chk
    import dma_cond_pkg::*;
#(
    parameter int CMD_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             eval_strobe,
    input logic [CMD_W-1:0] cmd_word,
    input logic             result_valid,
    input logic             irq_raise,
    input logic             wait_hold,
    input logic             branch_taken
);
    localparam int WL = lane_field_lsb(LANE_WAIT);
    localparam int BL = lane_field_lsb(LANE_BRANCH);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!result_valid && !irq_raise && !wait_hold && !branch_taken));

    p_wait_always_r3: assert property (@(posedge clk) disable iff (rst)
        (eval_strobe && cmd_word[WL +: 2] == 2'b11) |=> wait_hold);

    p_wait_never_r3: assert property (@(posedge clk) disable iff (rst)
        (eval_strobe && cmd_word[WL +: 2] == 2'b00) |=> !wait_hold);

    p_valid_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        eval_strobe |=> result_valid);

    p_no_valid_without_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !eval_strobe |=> !result_valid);

    p_irq_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
        irq_raise |-> result_valid);

    p_branch_always_r8: assert property (@(posedge clk) disable iff (rst)
        (eval_strobe && cmd_word[WL +: 2] == 2'b00 && cmd_word[BL +: 2] == 2'b11)
        |=> branch_taken);

    p_wait_blocks_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (result_valid && wait_hold) |-> !irq_raise);

    p_wait_keeps_branch_r9: assert property (@(posedge clk) disable iff (rst)
        (eval_strobe && cmd_word[WL +: 2] == 2'b11) |=> $stable(branch_taken));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !eval_strobe |=> ($stable(wait_hold) && $stable(branch_taken) && !irq_raise));
endmodule

bind dma_cond_eval dma_cond_eval_chk #(.CMD_W(CMD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .eval_strobe (eval_strobe),
    .cmd_word    (cmd_word),
    .result_valid(result_valid),
    .irq_raise   (irq_raise),
    .wait_hold   (wait_hold),
    .branch_taken(branch_taken)
);

// File: tb/test_dma_cond_eval.sv
module test_dma_cond_eval;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        eval_strobe = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [3:0]  dev_status = '0;
    logic [31:0] intr_select = '0;
    logic [31:0] branch_select = '0;
    logic [31:0] wait_select = '0;
    logic        result_valid, irq_raise, wait_hold, branch_taken;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        logic  irq;
        logic  hold;
        logic  br;
        string tag;
    } exp_t;
    exp_t q[$];

    // Bench model state
    logic hold_m = 1'b0;
    logic br_m   = 1'b0;

    always #2 clk = ~clk;

    dma_cond_eval i_dma_cond_eval (
        .clk          (clk),
        .rst          (rst),
        .eval_strobe  (eval_strobe),
        .cmd_word     (cmd_word),
        .dev_status   (dev_status),
        .intr_select  (intr_select),
        .branch_select(branch_select),
        .wait_select  (wait_select),
        .result_valid (result_valid),
        .irq_raise    (irq_raise),
        .wait_hold    (wait_hold),
        .branch_taken (branch_taken)
    );

    function automatic logic m_cond(input logic [3:0] st, input logic [31:0] sel);
        logic ok = 1'b1;
        for (int b = 0; b < 4; b++) begin
            if (sel[16+b] && (st[b] != sel[b])) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic m_fire(input logic [1:0] p, input logic c);
        return (p == 2'd3) || (p == 2'd1 && c) || (p == 2'd2 && !c);
    endfunction

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Driver: present one command for evaluation, strobe stays high until idle()
    task automatic evaluate(input logic [15:0] cmd, input logic [3:0] st,
                            input logic [31:0] isel, input logic [31:0] bsel,
                            input logic [31:0] wsel, input string tag);
        exp_t e;
        logic fi, fb, fw;
        @(negedge clk);
        cmd_word      = cmd;
        dev_status    = st;
        intr_select   = isel;
        branch_select = bsel;
        wait_select   = wsel;
        eval_strobe   = 1'b1;
        fi = m_fire(cmd[5:4], m_cond(st, isel));
        fb = m_fire(cmd[3:2], m_cond(st, bsel));
        fw = m_fire(cmd[1:0], m_cond(st, wsel));
        hold_m = fw;
        if (!fw) br_m = fb;
        e.irq  = fi && !fw;
        e.hold = hold_m;
        e.br   = br_m;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            eval_strobe = 1'b0;
            cmd_word    = 16'hFFFF;
        end
    endtask

    // Monitor: scoreboard comparison plus idle-hold checks
    initial begin
        logic s_seen, r_seen;
        exp_t e;
        forever begin
            @(posedge clk);
            s_seen = eval_strobe;
            r_seen = rst;
            #1;
            if (!r_seen) begin
                if (s_seen || result_valid) check(result_valid, s_seen, "R6", "result_valid");
                if (result_valid) begin
                    if (q.size() == 0) begin
                        checks++;
                        fails++;
                        $display("FAIL R6 unexpected result: actual 1 expected 0 at %0t", $time);
                    end else begin
                        e = q.pop_front();
                        check(irq_raise, e.irq, e.tag, "irq_raise");
                        check(wait_hold, e.hold, e.tag, "wait_hold");
                        check(branch_taken, e.br, e.tag, "branch_taken");
                    end
                end else begin
                    // R10 and R7: idle cycle keeps levels, no interrupt
                    check(irq_raise, 1'b0, "R10", "irq_raise idle");
                    check(wait_hold, hold_m, "R10", "wait_hold idle");
                    check(branch_taken, br_m, "R10", "branch_taken idle");
                end
            end
        end
    end

    task automatic reset_check();
        @(negedge clk);
        rst = 1'b1;
        eval_strobe = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(result_valid, 1'b0, "R1", "result_valid");
        check(irq_raise, 1'b0, "R1", "irq_raise");
        check(wait_hold, 1'b0, "R1", "wait_hold");
        check(branch_taken, 1'b0, "R1", "branch_taken");
        hold_m = 1'b0;
        br_m   = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    localparam logic [31:0] SEL_FULL5 = 32'h000F_0005;

    initial begin
        reset_check();
        idle(2);

        // R3 and R4: every policy on each field, condition true (5) and false (A)
        for (int lane = 0; lane < 3; lane++) begin
            for (int p = 0; p < 4; p++) begin
                for (int t = 0; t < 2; t++) begin
                    evaluate(16'(p << (2 * lane)), t ? 4'h5 : 4'hA,
                             SEL_FULL5, SEL_FULL5, SEL_FULL5, "R3");
                    idle(1);
                end
            end
        end

        // R2: partial mask, noise outside the fields
        evaluate(16'h0010, 4'b1101, 32'hFFF3_FFF1, 32'h0, 32'h0, "R2");
        idle(1);
        evaluate(16'h0010, 4'b1110, 32'h5553_5551, 32'h0, 32'h0, "R2");
        idle(1);
        // R2: empty mask always matches
        evaluate(16'h0010, 4'hC, 32'hFFF0_FFF3, 32'h0, 32'h0, "R2");
        idle(1);

        // R4: upper command bits ignored
        evaluate(16'hA5C0 | 16'h0030, 4'h0, 32'h0, 32'h0, 32'h0, "R4");
        idle(1);
        evaluate(16'hFFC0 | 16'h0004, 4'h3, 32'h0, 32'h000F_0003, 32'h0, "R4");
        idle(1);

        // R5: separate select registers with if-true on all fields
        evaluate(16'h0015, 4'h6, 32'h000F_0006, 32'h000F_0009, 32'h000F_0001, "R5");
        idle(1);
        evaluate(16'h0015, 4'h6, 32'h000F_0001, 32'h000F_0006, 32'h000F_0009, "R5");
        idle(1);

        // R8: branch set, cleared, set by if-false
        evaluate(16'h000C, 4'h0, 32'h0, 32'h0, 32'h0, "R8");
        idle(1);
        evaluate(16'h0000, 4'h0, 32'h0, 32'h0, 32'h0, "R8");
        idle(1);
        evaluate(16'h0008, 4'h2, 32'h0, 32'h000F_0001, 32'h0, "R8");
        idle(2);

        // R9: wait keeps branch at 1 and blocks interrupt
        evaluate(16'h003F, 4'h0, 32'h0, 32'h0, 32'h0, "R9");
        idle(1);
        evaluate(16'h0000, 4'h0, 32'h0, 32'h0, 32'h0, "R9");
        idle(1);
        evaluate(16'h003D, 4'h4, 32'h000F_0004, 32'h0, 32'h000F_0004, "R9");
        idle(3);

        // R6 and R7: back-to-back strobes
        evaluate(16'h0030, 4'h0, 32'h0, 32'h0, 32'h0, "R7");
        evaluate(16'h000C, 4'h0, 32'h0, 32'h0, 32'h0, "R6");
        evaluate(16'h0003, 4'h0, 32'h0, 32'h0, 32'h0, "R6");
        evaluate(16'h0020, 4'h1, 32'h000F_0001, 32'h0, 32'h0, "R6");
        idle(4);

        // R1: reset in mid-run clears the levels
        evaluate(16'h000F, 4'h0, 32'h0, 32'h0, 32'h0, "R1");
        idle(2);
        reset_check();
        idle(3);

        if (q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R6 missing results: actual %0d expected 0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        finished = 1;
        $finish;
    end

endmodule